// File: doc/BRIEF.md
# Aliased Peripheral Register Window Decoder

This block sits on a 16-bit processor address bus and serves a bank of eight 8-bit peripheral registers that appear many times over a larger region. Any address whose top three bits equal `001` (the span `$2000` to `$3FFF`) reaches the bank. The bottom three address bits pick one of the eight registers. Every address bit in between is discarded, so the bank repeats every eight bytes across the region, and the highest copies reach the same storage as the lowest.

A selected write stores the data byte into the indexed register on the clock edge. A selected read returns that register's contents on the same cycle. On the following cycle it raises a one-hot read pulse, so the peripheral behind the window can react to the access, for example by clearing a flag. The decoder presents all eight registers in parallel for that peripheral logic to use. What each register means is left to the peripheral.

Top module: `regwin_decoder`

## Requirements
- R1: `winSel` is high exactly when a read or write strobe is active and the address lies in `$2000`–`$3FFF`, that is, when address bits [15:13] equal `3'b001`. It is low for every other address, for example `$1FFC`, `$4004`, `$0000` and `$E000`.
- R2: `regIdx` equals address bits [2:0]. Address bits [12:3] have no effect on the selection, so `$2008` and `$2000` reach register 0, and `$2F0B` reaches register 3.
- R3: A write strobe with `winSel` high stores `wrData` into register `regIdx` at the next rising clock edge. The other seven registers keep their values.
- R4: A write strobe to an address outside the region leaves all eight registers unchanged.
- R5: While a read strobe is active and `winSel` is high, `rdData` shows the indexed register in the same cycle. In every other case `rdData` is zero.
- R6: `rdPulse` is a one-hot vector in which bit n stands for register n. In the cycle after a selected read of register n it is exactly `1 << n`. It is zero in all other cycles.
- R7: A synchronous reset (`rst` high at a rising edge) clears all eight registers and `rdPulse`.
- R8: The top aliases, such as `$3F80`–`$3F87` and `$3FF8`–`$3FFF`, reach the register given by their low three bits, just as the lowest copy does.
- R9: `regsFlat` presents register n in bits [8n+7:8n] at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addrBus | input | 16 | Processor address |
| wrData | input | 8 | Byte to store on a selected write |
| rdEn | input | 1 | Read strobe for the current cycle |
| wrEn | input | 1 | Write strobe for the current cycle |
| winSel | output | 1 | Window chip-select |
| regIdx | output | 3 | Register index taken from the low address bits |
| rdData | output | 8 | Read data; zero unless a selected read is active |
| rdPulse | output | 8 | One-hot, one-cycle read notification per register |
| regsFlat | output | 64 | Contents of all eight registers, register n at bits [8n+7:8n] |

## Verification
The assertions assume that the read and write strobes are never active in the same cycle, and that the inputs change only between clock edges. The bench therefore drives each access on the falling edge and raises only one strobe per access. It clears both strobes before the next access, so every write and read stands alone. The assertions check the property-level rules from the ports. The write-landing check and the read-pulse check compare against a copy of the previous cycle's access that the checker keeps in its own registers.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  // Register bank geometry shared by every unit of the decoder.
  localparam int REG_IDX_W = 3;
  localparam int REG_COUNT = 1 << REG_IDX_W;

  // Strobe bundle handed from the decode control to the datapath.
  typedef struct packed {
    logic                 hit;    // address falls in the window and a strobe is active
    logic                 wrGo;   // selected write this cycle
    logic                 rdGo;   // selected read this cycle
    logic [REG_COUNT-1:0] wrSel;  // one-hot write target
    logic [REG_COUNT-1:0] rdSel;  // one-hot read target
  } winStrobe_t;

endpackage

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int              ADDR_W      = 16,
  parameter int              REGION_W    = 3,
  parameter logic [REGION_W-1:0] REGION_CODE = 3'b001
) (
  input  logic [ADDR_W-1:0]    addrBus,
  input  logic                 rdEn,
  input  logic                 wrEn,
  output winStrobe_t           strobes,
  output logic [REG_IDX_W-1:0] regIdx
);

  localparam int REGION_LSB = ADDR_W - REGION_W;
  localparam int MID_MSB    = REGION_LSB - 1;

  logic [REGION_W-1:0]  regionBits;
  logic                 regionMatch;
  logic                 anyStrobe;
  logic [REG_COUNT-1:0] idxOneHot;
  logic                 unusedMidBits;

  // Upper bits pick the region, lower bits pick the register.
  assign regionBits    = addrBus[ADDR_W-1:REGION_LSB];
  assign regIdx        = addrBus[REG_IDX_W-1:0];
  // The alias bits between the two fields are discarded on purpose.
  assign unusedMidBits = ^addrBus[MID_MSB:REG_IDX_W];

  assign regionMatch = (regionBits == REGION_CODE);
  assign anyStrobe   = rdEn | wrEn;

  // One-hot index decode, one comparator per register.
  for (genvar gIdx = 0; gIdx < REG_COUNT; gIdx++) begin : g_idxDecode
    assign idxOneHot[gIdx] = (regIdx == REG_IDX_W'(gIdx));
  end

  always_comb begin
    strobes.hit   = regionMatch & anyStrobe;
    strobes.wrGo  = regionMatch & wrEn;
    strobes.rdGo  = regionMatch & rdEn;
    strobes.wrSel = strobes.wrGo ? idxOneHot : '0;
    strobes.rdSel = strobes.rdGo ? idxOneHot : '0;
  end

endmodule

// File: rtl/regwin_datapath.sv
module regwin_datapath
  import regwin_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  winStrobe_t                    strobes,
  input  logic [REG_IDX_W-1:0]          regIdx,
  input  logic [DATA_W-1:0]             wrData,
  output logic [DATA_W-1:0]             rdData,
  output logic [REG_COUNT-1:0]          rdPulse,
  output logic [REG_COUNT*DATA_W-1:0]   regsFlat
);

  logic [DATA_W-1:0] regBank [REG_COUNT];

  // Per-register storage, each loaded only by its own write strobe.
  for (genvar gReg = 0; gReg < REG_COUNT; gReg++) begin : g_regSlot
    always_ff @(posedge clk) begin
      if (rst) begin
        regBank[gReg] <= '0;
      end else if (strobes.wrSel[gReg]) begin
        regBank[gReg] <= wrData;
      end
    end
    assign regsFlat[gReg*DATA_W +: DATA_W] = regBank[gReg];
  end

  // Read mux gated by the selected-read strobe.
  always_comb begin
    rdData = '0;
    if (strobes.rdGo) begin
      rdData = regBank[regIdx];
    end
  end

  // One-cycle notification after a selected read.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdPulse <= '0;
    end else begin
      rdPulse <= strobes.rdSel;
    end
  end

endmodule

// File: rtl/regwin_decoder.sv
module regwin_decoder
  import regwin_pkg::*;
#(
  parameter int                  ADDR_W      = 16,
  parameter int                  DATA_W      = 8,
  parameter int                  REGION_W    = 3,
  parameter logic [REGION_W-1:0] REGION_CODE = 3'b001
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           addrBus,
  input  logic [DATA_W-1:0]           wrData,
  input  logic                        rdEn,
  input  logic                        wrEn,
  output logic                        winSel,
  output logic [REG_IDX_W-1:0]        regIdx,
  output logic [DATA_W-1:0]           rdData,
  output logic [REG_COUNT-1:0]        rdPulse,
  output logic [REG_COUNT*DATA_W-1:0] regsFlat
);

  winStrobe_t strobes;

  regwin_ctrl #(
    .ADDR_W     (ADDR_W),
    .REGION_W   (REGION_W),
    .REGION_CODE(REGION_CODE)
  ) u_ctrl (
    .addrBus(addrBus),
    .rdEn   (rdEn),
    .wrEn   (wrEn),
    .strobes(strobes),
    .regIdx (regIdx)
  );

  regwin_datapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .regIdx  (regIdx),
    .wrData  (wrData),
    .rdData  (rdData),
    .rdPulse (rdPulse),
    .regsFlat(regsFlat)
  );

  assign winSel = strobes.hit;

endmodule

// File: rtl/regwin_checker.sv
module regwin_checker
  import regwin_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic                        clk,
  input logic                        rst,
  input logic [ADDR_W-1:0]           addrBus,
  input logic [DATA_W-1:0]           wrData,
  input logic                        rdEn,
  input logic                        wrEn,
  input logic                        winSel,
  input logic [REG_IDX_W-1:0]        regIdx,
  input logic [DATA_W-1:0]           rdData,
  input logic [REG_COUNT-1:0]        rdPulse,
  input logic [REG_COUNT*DATA_W-1:0] regsFlat
);

  // Record of the previous cycle's access, kept here rather than in the design.
  logic                 lastWr;
  logic                 lastRd;
  logic [REG_IDX_W-1:0] lastIdx;
  logic [DATA_W-1:0]    lastData;

  always_ff @(posedge clk) begin
    if (rst) begin
      lastWr   <= 1'b0;
      lastRd   <= 1'b0;
      lastIdx  <= '0;
      lastData <= '0;
    end else begin
      lastWr   <= wrEn & winSel;
      lastRd   <= rdEn & winSel;
      lastIdx  <= addrBus[REG_IDX_W-1:0];
      lastData <= wrData;
    end
  end

  // R1: select never asserts outside the window span
  p_sel_in_span_r1: assert property (@(posedge clk) disable iff (rst)
    winSel |-> (addrBus >= 16'h2000 && addrBus <= 16'h3FFF));

  // R3: a selected write is visible in its register one cycle later
  p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
    lastWr |-> (regsFlat[lastIdx*DATA_W +: DATA_W] == lastData));

  // R4: without a selected write no register moves
  p_hold_when_unselected_r4: assert property (@(posedge clk) disable iff (rst)
    (!rst && !(wrEn && winSel)) |=> $stable(regsFlat));

  // R5: read data is zero unless a selected read is in progress
  p_rd_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !(rdEn && winSel) |-> (rdData == '0));

  // R6: notification follows a selected read and is one-hot
  p_rd_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    lastRd |-> (rdPulse == (REG_COUNT'(1) << lastIdx)));

  p_rd_pulse_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !lastRd |-> (rdPulse == '0));

  p_rd_pulse_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rdPulse));

endmodule

bind regwin_decoder regwin_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .addrBus (addrBus),
  .wrData  (wrData),
  .rdEn    (rdEn),
  .wrEn    (wrEn),
  .winSel  (winSel),
  .regIdx  (regIdx),
  .rdData  (rdData),
  .rdPulse (rdPulse),
  .regsFlat(regsFlat)
);

// File: tb/regwin_decoder_test.sv
`timescale 1ns/1ps
module regwin_decoder_test;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] addrBus;
  logic [7:0]  wrData;
  logic        rdEn;
  logic        wrEn;
  logic        winSel;
  logic [2:0]  regIdx;
  logic [7:0]  rdData;
  logic [7:0]  rdPulse;
  logic [63:0] regsFlat;

  int checks   = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  regwin_decoder uut (
    .clk     (clk),
    .rst     (rst),
    .addrBus (addrBus),
    .wrData  (wrData),
    .rdEn    (rdEn),
    .wrEn    (wrEn),
    .winSel  (winSel),
    .regIdx  (regIdx),
    .rdData  (rdData),
    .rdPulse (rdPulse),
    .regsFlat(regsFlat)
  );

  // Vector: {isRead, address, write data or expected read data}
  localparam int NVEC = 23;
  localparam logic [24:0] VECS [NVEC] = '{
    {1'b0, 16'h2000, 8'h11},  // register 0
    {1'b0, 16'h2009, 8'h22},  // alias of register 1
    {1'b0, 16'h3FFA, 8'h33},  // top alias, register 2
    {1'b0, 16'h2F0B, 8'h44},  // middle alias, register 3
    {1'b0, 16'h1FFC, 8'h99},  // just below window
    {1'b0, 16'h4004, 8'hAA},  // just above window
    {1'b0, 16'h3004, 8'h55},  // register 4
    {1'b1, 16'h2000, 8'h11},
    {1'b1, 16'h3FF8, 8'h11},
    {1'b1, 16'h2001, 8'h22},
    {1'b1, 16'h3F82, 8'h33},
    {1'b1, 16'h2A0B, 8'h44},
    {1'b1, 16'h2004, 8'h55},
    {1'b1, 16'h2005, 8'h00},
    {1'b1, 16'h3FFF, 8'h00},
    {1'b0, 16'h3FFF, 8'h77},  // register 7 through top address
    {1'b1, 16'h2007, 8'h77},
    {1'b1, 16'h0000, 8'h00},  // outside, reads zero
    {1'b1, 16'hE000, 8'h00},  // outside, reads zero
    {1'b0, 16'h2010, 8'h5A},  // overwrite register 0
    {1'b1, 16'h3FF0, 8'h5A},
    {1'b1, 16'h2002, 8'h33},
    {1'b1, 16'h4002, 8'h00}
  };

  task automatic check(input logic ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic isRead, input logic [15:0] addr,
                        input logic [7:0] val);
    logic       inWin;
    logic [7:0] expPulse;
    inWin    = (addr >= 16'h2000) && (addr <= 16'h3FFF);
    expPulse = (isRead && inWin) ? (8'h01 << addr[2:0]) : 8'h00;
    @(negedge clk);
    addrBus = addr;
    wrData  = isRead ? 8'h00 : val;
    rdEn    = isRead;
    wrEn    = !isRead;
    #1;
    check(winSel == inWin, "R1 select", 64'(winSel), 64'(inWin));
    if (inWin) check(regIdx == addr[2:0], "R2 index", 64'(regIdx), 64'(addr[2:0]));
    if (isRead) check(rdData == val, "R5/R8 read data", 64'(rdData), 64'(val));
    @(posedge clk);
    #1;
    check(rdPulse == expPulse, "R6 read pulse", 64'(rdPulse), 64'(expPulse));
    @(negedge clk);
    rdEn = 1'b0;
    wrEn = 1'b0;
  endtask

  initial begin
    #500000;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] snap;
    rst     = 1'b1;
    addrBus = 16'h0000;
    wrData  = 8'h00;
    rdEn    = 1'b0;
    wrEn    = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R7: reset state
    check(regsFlat == 64'h0, "R7 reset regs", regsFlat, 64'h0);
    check(rdPulse == 8'h0, "R7 reset pulse", 64'(rdPulse), 64'h0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      access(VECS[i][24], VECS[i][23:8], VECS[i][7:0]);
    end

    // R3/R4/R9: full bank layout after the table
    #1;
    check(regsFlat == 64'h7700_0055_4433_225A, "R3/R4/R9 bank contents",
          regsFlat, 64'h7700_0055_4433_225A);

    // R4: outside writes with alias-like low bits leave the bank alone
    snap = regsFlat;
    access(1'b0, 16'h5FFF, 8'hEE);
    access(1'b0, 16'h1FF8, 8'hEE);
    #1;
    check(regsFlat == snap, "R4 outside writes ignored", regsFlat, snap);

    // R2: alias bits only; $2008 and $2000 hit the same register
    access(1'b0, 16'h2008, 8'hC3);
    access(1'b1, 16'h2000, 8'hC3);
    check(regsFlat[7:0] == 8'hC3, "R2/R9 alias write slot", 64'(regsFlat[7:0]), 64'hC3);

    // R8: top alias of register 5
    access(1'b0, 16'h3F85, 8'h6D);
    access(1'b1, 16'h202D, 8'h6D);

    // R6: no pulse in an idle cycle
    @(posedge clk);
    #1;
    check(rdPulse == 8'h0, "R6 idle pulse", 64'(rdPulse), 64'h0);

    // R7: reset clears a populated bank
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check(regsFlat == 64'h0, "R7 reset clears", regsFlat, 64'h0);
    @(negedge clk);
    rst = 1'b0;
    access(1'b1, 16'h3FFF, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule